// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block keeps the one-bit record of whether a processor core is halted in debug mode, and it sequences the way in and the way out. The core reports three things to it: an external halt request, the completion of a single-stepped instruction, and the execution of the debug-return instruction. It also reports every trap with its exception code. On entry, the controller saves the current PC and privilege. It records why the core stopped, then steers the fetch unit to a fixed debug ROM address at machine privilege. On debug-return, it steers fetch back to the saved PC and hands back the saved privilege. If the step control bit was set at that moment, it arms one step so that the core halts again after one instruction.

While the flag is set, the controller asserts two outputs. One masks all interrupts, and the other disables the substitution of the load/store privilege from the machine status register. Any breakpoint trap taken in debug mode is sent back to the debug ROM entry. The debug-return instruction is legal only while the flag is set, whatever the current privilege. The flag is kept apart from the recorded cause, so the cause survives the return and can still be read afterwards.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset the outputs read as follows: dbg_mode_o=0, cause_o=0, redir_valid_o=0, illegal_o=0, irq_mask_o=0 and mprv_off_o=0. priv_o reads 3 (machine) and redir_pc_o reads 0.
- R2: halt_req_i high outside debug mode gives the following one cycle later: dbg_mode_o=1, cause_o=3 (halt) and a one-cycle redir_valid_o, with redir_pc_o equal to ROM_ENTRY and priv_o=3.
- R3: At entry, pc_i and priv_i of the entry cycle are saved. The saved values are later returned by debug-return.
- R4: step_done_i enters debug mode with cause_o=4 (step) only when a step is armed. When no step is armed, step_done_i has no effect.
- R5: If halt_req_i and an armed step_done_i arrive in the same cycle, one entry occurs, with cause_o=3. The armed step is consumed.
- R6: dret_i outside debug mode raises illegal_o for one cycle, one cycle later, for any priv_i including 3. It changes no other output.
- R7: dret_i in debug mode gives the following one cycle later: dbg_mode_o=0 and a one-cycle redir_valid_o, with redir_pc_o equal to the saved PC and priv_o equal to the saved privilege. cause_o keeps its value.
- R8: If step_ctrl_i is 1 at debug-return, one step is armed. If it is 0, any armed step is discarded.
- R9: irq_mask_o and mprv_off_o are high in exactly the cycles in which dbg_mode_o is high.
- R10: In debug mode, a trap with trap_code_i equal to BRK_CODE (default 3) redirects to ROM_ENTRY at priv_o=3 and leaves the block in debug mode. Other trap codes in debug mode, and all traps outside debug mode, cause no redirect.
- R11: In debug mode, halt_req_i and step_done_i have no effect.
- R12: In debug mode, dret_i takes priority over a trap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | External halt request |
| step_done_i | input | 1 | Pulse: a stepped instruction retired |
| dret_i | input | 1 | Pulse: debug-return instruction executed |
| step_ctrl_i | input | 1 | Step control bit from the debug status register |
| trap_i | input | 1 | Pulse: a trap is being taken |
| trap_code_i | input | TRAP_W | Exception code of the trap |
| priv_i | input | 2 | Current privilege level |
| pc_i | input | XLEN | PC of the current instruction |
| dbg_mode_o | output | 1 | Debug mode flag |
| cause_o | output | 3 | Recorded entry cause (0 none, 1 breakpoint, 3 halt, 4 step) |
| redir_valid_o | output | 1 | Pulse: redirect fetch to redir_pc_o at priv_o |
| redir_pc_o | output | XLEN | Redirect target PC |
| priv_o | output | 2 | Privilege to apply with the redirect |
| illegal_o | output | 1 | Pulse: illegal debug-return |
| irq_mask_o | output | 1 | Mask all interrupts |
| mprv_off_o | output | 1 | Disable the load/store privilege substitution |

## Verification
A wrong debug flag appears at once on dbg_mode_o, irq_mask_o and mprv_off_o. It also shows as a missing or extra redirect or illegal pulse on the next strobe. A corrupted saved PC or saved privilege stays hidden until the next debug-return, so the bench always pairs an entry with a later return and compares redir_pc_o and priv_o. A stale armed step surfaces only when a later step_done_i enters (or fails to enter) debug mode, so the bench injects step_done_i after returns made with and without step_ctrl_i set.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

   typedef enum logic [2:0] {
      DC_NONE  = 3'd0,
      DC_BREAK = 3'd1,
      DC_HALT  = 3'd3,
      DC_STEP  = 3'd4
   } dbg_cause_e;

   localparam logic [1:0] PRIV_MACHINE = 2'b11;

   typedef struct packed {
      logic       go;
      dbg_cause_e why;
   } entry_req_t;

endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
   import dbg_mode_pkg::*;
#(
   parameter bit HAS_STEP = 1'b1
) (
   input  logic       in_dbg,
   input  logic       halt_req,
   input  logic       step_done,
   input  logic       step_armed,
   output entry_req_t req
);

   logic step_hit;

   generate
      if (HAS_STEP) begin : g_step
         assign step_hit = step_done & step_armed;
      end else begin : g_nostep
         logic unused_step;
         assign unused_step = step_done ^ step_armed;
         assign step_hit = 1'b0;
      end
   endgenerate

   // halt has precedence over a step completion in the same cycle
   always_comb begin
      req.go  = !in_dbg && (halt_req || step_hit);
      req.why = DC_NONE;
      if (req.go) begin
         req.why = halt_req ? DC_HALT : DC_STEP;
      end
   end

endmodule

// File: rtl/dbg_exit_ctrl.sv
module dbg_exit_ctrl #(
   parameter int unsigned TRAP_W   = 4,
   parameter int unsigned BRK_CODE = 3
) (
   input  logic              in_dbg,
   input  logic              dret,
   input  logic              trap,
   input  logic [TRAP_W-1:0] trap_code,
   output logic              leave_go,
   output logic              bad_dret,
   output logic              brk_go
);

   localparam logic [TRAP_W-1:0] BRK = TRAP_W'(BRK_CODE);

   always_comb begin
      leave_go = in_dbg && dret;
      bad_dret = !in_dbg && dret;
      brk_go   = in_dbg && !dret && trap && (trap_code == BRK);
   end

endmodule

// File: rtl/dbg_state_regs.sv
module dbg_state_regs
   import dbg_mode_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter bit          HAS_STEP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  entry_req_t      req,
   input  logic            leave_go,
   input  logic            step_ctrl,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [1:0]      cur_priv,
   output logic            in_dbg,
   output dbg_cause_e      cause,
   output logic [XLEN-1:0] saved_pc,
   output logic [1:0]      saved_priv,
   output logic            step_armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_dbg     <= 1'b0;
         cause      <= DC_NONE;
         saved_pc   <= '0;
         saved_priv <= PRIV_MACHINE;
      end else if (req.go) begin
         in_dbg     <= 1'b1;
         cause      <= req.why;
         saved_pc   <= cur_pc;
         saved_priv <= cur_priv;
      end else if (leave_go) begin
         in_dbg     <= 1'b0;
      end
   end

   generate
      if (HAS_STEP) begin : g_arm
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
            end else if (req.go) begin
               armed_q <= 1'b0;
            end else if (leave_go) begin
               armed_q <= step_ctrl;
            end
         end
         assign step_armed = armed_q;
      end else begin : g_noarm
         logic unused_ctrl;
         assign unused_ctrl = step_ctrl;
         assign step_armed  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbg_redirect.sv
module dbg_redirect
   import dbg_mode_pkg::*;
#(
   parameter int unsigned   XLEN   = 32,
   parameter logic [XLEN-1:0] ROM_PC = 'h800
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enter_go,
   input  logic            leave_go,
   input  logic            brk_go,
   input  logic            bad_dret,
   input  logic [XLEN-1:0] saved_pc,
   input  logic [1:0]      saved_priv,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_pc,
   output logic [1:0]      redir_priv,
   output logic            illegal
);

   logic            any_go;
   logic [XLEN-1:0] next_pc;
   logic [1:0]      next_priv;

   always_comb begin
      any_go    = enter_go || leave_go || brk_go;
      next_pc   = leave_go ? saved_pc   : ROM_PC;
      next_priv = leave_go ? saved_priv : PRIV_MACHINE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         redir_pc    <= '0;
         redir_priv  <= PRIV_MACHINE;
         illegal     <= 1'b0;
      end else begin
         redir_valid <= any_go;
         illegal     <= bad_dret;
         if (any_go) begin
            redir_pc   <= next_pc;
            redir_priv <= next_priv;
         end
      end
   end

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
   import dbg_mode_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned TRAP_W    = 4,
   parameter int unsigned BRK_CODE  = 3,
   parameter logic [63:0] ROM_ENTRY = 64'h800,
   parameter bit          HAS_STEP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_req_i,
   input  logic              step_done_i,
   input  logic              dret_i,
   input  logic              step_ctrl_i,
   input  logic              trap_i,
   input  logic [TRAP_W-1:0] trap_code_i,
   input  logic [1:0]        priv_i,
   input  logic [XLEN-1:0]   pc_i,
   output logic              dbg_mode_o,
   output logic [2:0]        cause_o,
   output logic              redir_valid_o,
   output logic [XLEN-1:0]   redir_pc_o,
   output logic [1:0]        priv_o,
   output logic              illegal_o,
   output logic              irq_mask_o,
   output logic              mprv_off_o
);

   localparam logic [XLEN-1:0] ROM_PC = ROM_ENTRY[XLEN-1:0];

   generate
      if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
         $error("dbg_mode_ctrl: XLEN out of range");
      end
      if (XLEN < 64 && (ROM_ENTRY >> XLEN) != 64'd0) begin : g_bad_rom
         $error("dbg_mode_ctrl: ROM_ENTRY wider than XLEN");
      end
      if (TRAP_W < 2 || TRAP_W > 16) begin : g_bad_trapw
         $error("dbg_mode_ctrl: TRAP_W out of range");
      end
      if (BRK_CODE >= (1 << TRAP_W)) begin : g_bad_brk
         $error("dbg_mode_ctrl: BRK_CODE does not fit TRAP_W");
      end
   endgenerate

   entry_req_t      req;
   logic            in_dbg;
   logic            step_armed;
   logic            leave_go;
   logic            bad_dret;
   logic            brk_go;
   dbg_cause_e      cause;
   logic [XLEN-1:0] saved_pc;
   logic [1:0]      saved_priv;

   dbg_entry_arb #(
      .HAS_STEP (HAS_STEP)
   ) u_arb (
      .in_dbg     (in_dbg),
      .halt_req   (halt_req_i),
      .step_done  (step_done_i),
      .step_armed (step_armed),
      .req        (req)
   );

   dbg_exit_ctrl #(
      .TRAP_W   (TRAP_W),
      .BRK_CODE (BRK_CODE)
   ) u_exit (
      .in_dbg    (in_dbg),
      .dret      (dret_i),
      .trap      (trap_i),
      .trap_code (trap_code_i),
      .leave_go  (leave_go),
      .bad_dret  (bad_dret),
      .brk_go    (brk_go)
   );

   dbg_state_regs #(
      .XLEN     (XLEN),
      .HAS_STEP (HAS_STEP)
   ) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .leave_go   (leave_go),
      .step_ctrl  (step_ctrl_i),
      .cur_pc     (pc_i),
      .cur_priv   (priv_i),
      .in_dbg     (in_dbg),
      .cause      (cause),
      .saved_pc   (saved_pc),
      .saved_priv (saved_priv),
      .step_armed (step_armed)
   );

   dbg_redirect #(
      .XLEN   (XLEN),
      .ROM_PC (ROM_PC)
   ) u_redir (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_go    (req.go),
      .leave_go    (leave_go),
      .brk_go      (brk_go),
      .bad_dret    (bad_dret),
      .saved_pc    (saved_pc),
      .saved_priv  (saved_priv),
      .redir_valid (redir_valid_o),
      .redir_pc    (redir_pc_o),
      .redir_priv  (priv_o),
      .illegal     (illegal_o)
   );

   assign dbg_mode_o = in_dbg;
   assign cause_o    = cause;
   assign irq_mask_o = in_dbg;
   assign mprv_off_o = in_dbg;

endmodule

// File: rtl/dbg_mode_chk.sv
module dbg_mode_chk #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned TRAP_W    = 4,
   parameter int unsigned BRK_CODE  = 3,
   parameter logic [63:0] ROM_ENTRY = 64'h800
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt_req_i,
   input logic              dret_i,
   input logic              trap_i,
   input logic [TRAP_W-1:0] trap_code_i,
   input logic              dbg_mode_o,
   input logic [2:0]        cause_o,
   input logic              redir_valid_o,
   input logic [XLEN-1:0]   redir_pc_o,
   input logic [1:0]        priv_o,
   input logic              illegal_o
);

   localparam logic [XLEN-1:0]   ROM_PC = ROM_ENTRY[XLEN-1:0];
   localparam logic [TRAP_W-1:0] BRK    = TRAP_W'(BRK_CODE);

   a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_mode_o && halt_req_i) |=>
         (dbg_mode_o && cause_o == 3'd3 && redir_valid_o && redir_pc_o == ROM_PC));

   a_r2_entry_target: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_mode_o) |-> (redir_valid_o && redir_pc_o == ROM_PC && priv_o == 2'b11));

   a_r6_bad_dret: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbg_mode_o && dret_i) |=> (illegal_o && !redir_valid_o));

   a_r7_dret_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode_o && dret_i) |=> (!dbg_mode_o && redir_valid_o && !illegal_o));

   a_r7_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dbg_mode_o) |-> $stable(cause_o));

   a_r11_stay: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode_o && !dret_i) |=> (dbg_mode_o && $stable(cause_o)));

   a_r10_brk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode_o && !dret_i && trap_i && trap_code_i == BRK) |=>
         (redir_valid_o && redir_pc_o == ROM_PC && priv_o == 2'b11));

endmodule

bind dbg_mode_ctrl dbg_mode_chk #(
   .XLEN      (XLEN),
   .TRAP_W    (TRAP_W),
   .BRK_CODE  (BRK_CODE),
   .ROM_ENTRY (ROM_ENTRY)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .halt_req_i    (halt_req_i),
   .dret_i        (dret_i),
   .trap_i        (trap_i),
   .trap_code_i   (trap_code_i),
   .dbg_mode_o    (dbg_mode_o),
   .cause_o       (cause_o),
   .redir_valid_o (redir_valid_o),
   .redir_pc_o    (redir_pc_o),
   .priv_o        (priv_o),
   .illegal_o     (illegal_o)
);

// File: tb/dbg_mode_ctrl_tb.sv
module dbg_mode_ctrl_tb;

   localparam int unsigned XLEN = 32;
   localparam logic [31:0] ROM  = 32'h800;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            halt_req = 1'b0, step_done = 1'b0, dret = 1'b0;
   logic            step_ctrl = 1'b0, trap = 1'b0;
   logic [3:0]      trap_code = '0;
   logic [1:0]      priv = 2'd0;
   logic [XLEN-1:0] pc = '0;

   logic            dbg, rv, ill, irqm, mprv;
   logic [2:0]      cause;
   logic [XLEN-1:0] rpc;
   logic [1:0]      rpriv;

   dbg_mode_ctrl u_dut (
      .clk (clk), .rst_n (rst_n),
      .halt_req_i (halt_req), .step_done_i (step_done), .dret_i (dret),
      .step_ctrl_i (step_ctrl), .trap_i (trap), .trap_code_i (trap_code),
      .priv_i (priv), .pc_i (pc),
      .dbg_mode_o (dbg), .cause_o (cause), .redir_valid_o (rv),
      .redir_pc_o (rpc), .priv_o (rpriv), .illegal_o (ill),
      .irq_mask_o (irqm), .mprv_off_o (mprv)
   );

   always #10 clk = ~clk;

   int    tests = 0;
   int    fails = 0;
   bit    done  = 1'b0;
   string cur_req = "R1";

   // behavioural reference model
   bit          m_dbg, m_rv, m_ill, m_arm;
   int          m_cause;
   logic [31:0] m_dpc, m_rpc;
   int          m_spriv, m_priv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dbg = 0; m_rv = 0; m_ill = 0; m_arm = 0;
         m_cause = 0; m_dpc = 0; m_rpc = 0; m_spriv = 3; m_priv = 3;
      end else begin
         bit was_dbg;
         was_dbg = m_dbg;
         m_rv = 0;
         m_ill = 0;
         if (!was_dbg) begin
            if (dret) m_ill = 1;
            if (halt_req || (step_done && m_arm)) begin
               m_cause = halt_req ? 3 : 4;
               m_dbg = 1; m_arm = 0;
               m_dpc = pc; m_spriv = int'(priv);
               m_rv = 1; m_rpc = ROM; m_priv = 3;
            end
         end else if (dret) begin
            m_dbg = 0; m_arm = step_ctrl;
            m_rv = 1; m_rpc = m_dpc; m_priv = m_spriv;
         end else if (trap && trap_code == 4'd3) begin
            m_rv = 1; m_rpc = ROM; m_priv = 3;
         end
      end
   end

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "dbg_mode_o", dbg, m_dbg);
         chk(cur_req, "cause_o", cause, m_cause);
         chk(cur_req, "redir_valid_o", rv, m_rv);
         if (m_rv) chk(cur_req, "redir_pc_o", rpc, m_rpc);
         if (m_rv) chk(cur_req, "priv_o", rpriv, m_priv);
         chk(cur_req, "illegal_o", ill, m_ill);
         chk("R9", "irq_mask_o", irqm, m_dbg);
         chk("R9", "mprv_off_o", mprv, m_dbg);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         halt_req = 0; step_done = 0; dret = 0; trap = 0;
      end
   endtask

   task automatic pulse_halt();
      @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
   endtask

   task automatic pulse_dret(input bit sc);
      @(negedge clk); dret = 1; step_ctrl = sc; @(negedge clk); dret = 0; step_ctrl = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      cur_req = "R1";
      chk("R1", "dbg_mode_o", dbg, 0);
      chk("R1", "cause_o", cause, 0);
      chk("R1", "priv_o", rpriv, 3);
      chk("R1", "redir_valid_o", rv, 0);
      idle(2);

      cur_req = "R6";
      priv = 2'd3;
      @(negedge clk); dret = 1;
      @(negedge clk); dret = 0;
      chk("R6", "illegal_o", ill, 1);
      chk("R6", "dbg_mode_o", dbg, 0);
      idle(2);

      cur_req = "R4";
      @(negedge clk); step_done = 1;
      @(negedge clk); step_done = 0;
      chk("R4", "no entry unarmed", dbg, 0);

      cur_req = "R10";
      @(negedge clk); trap = 1; trap_code = 4'd3;
      @(negedge clk); trap = 0;
      chk("R10", "no redirect outside", rv, 0);

      cur_req = "R2";
      pc = 32'h1234; priv = 2'd0;
      pulse_halt();
      chk("R2", "cause_o", cause, 3);
      chk("R2", "redir_pc_o", rpc, ROM);
      chk("R2", "irq_mask_o", irqm, 1);
      pc = 32'h5555; priv = 2'd3;
      idle(2);

      cur_req = "R11";
      @(negedge clk); halt_req = 1; step_done = 1;
      @(negedge clk); halt_req = 0; step_done = 0;
      chk("R11", "no redirect", rv, 0);
      chk("R11", "cause kept", cause, 3);

      cur_req = "R10";
      @(negedge clk); trap = 1; trap_code = 4'd3;
      @(negedge clk); trap = 0;
      chk("R10", "brk redirect", rpc, ROM);
      chk("R10", "brk valid", rv, 1);
      @(negedge clk); trap = 1; trap_code = 4'd2;
      @(negedge clk); trap = 0;
      chk("R10", "other code no redirect", rv, 0);
      chk("R10", "still debug", dbg, 1);

      cur_req = "R7";
      pulse_dret(1'b0);
      chk("R3", "return pc", rpc, 32'h1234);
      chk("R3", "return priv", rpriv, 0);
      chk("R7", "flag cleared", dbg, 0);
      chk("R7", "cause kept", cause, 3);
      idle(2);

      cur_req = "R8";
      pc = 32'h2000; priv = 2'd1;
      pulse_halt();
      idle(1);
      pulse_dret(1'b1);
      pc = 32'h2004;
      idle(2);
      chk("R8", "armed not yet entered", dbg, 0);
      @(negedge clk); step_done = 1;
      @(negedge clk); step_done = 0;
      chk("R8", "step entry", dbg, 1);
      chk("R4", "step cause", cause, 4);

      cur_req = "R5";
      pulse_dret(1'b1);
      pc = 32'h3000;
      @(negedge clk); halt_req = 1; step_done = 1;
      @(negedge clk); halt_req = 0; step_done = 0;
      chk("R5", "halt wins", cause, 3);
      pulse_dret(1'b0);
      chk("R5", "return pc", rpc, 32'h3000);
      @(negedge clk); step_done = 1;
      @(negedge clk); step_done = 0;
      chk("R5", "step consumed", dbg, 0);

      cur_req = "R12";
      pc = 32'h4000;
      pulse_halt();
      @(negedge clk); dret = 1; trap = 1; trap_code = 4'd3;
      @(negedge clk); dret = 0; trap = 0;
      chk("R12", "dret wins pc", rpc, 32'h4000);
      chk("R12", "left debug", dbg, 0);
      idle(3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule